// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block holds the instructions waiting for one class of functional unit in an out-of-order floating-point core. The issue stage hands it an operation, an address field and two operands. Each operand is either a value or the tag of the station that will produce it, as looked up in the rename table. Every entry watches a shared result bus. When the bus carries a tag that an entry is waiting for, the entry copies the broadcast value and stops waiting.

Once both operands of an entry are present, the entry competes for the functional unit. The oldest competing entry is offered on the dispatch port. A value on the result bus is forwarded straight to that port, so an entry can leave in the same cycle its last operand arrives. An entry keeps its slot after dispatch. The slot is released when the entry's own tag comes back on the result bus, because that tag is the name consumers wait on.

Both ports with data use valid/ready. On the issue port, `iss_ready` depends only on free slots and `flush`, and never on `iss_valid`; a transfer happens on a clock edge where both are high. On the dispatch port, `disp_ready` means the functional unit is free. `disp_valid` never depends on `disp_ready`. While `disp_ready` is low the offered entry may change to an older one that has just become ready, because dispatch is ordered by age and not held. A transfer happens on an edge where both are high.

Top module: `rs_station_array`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1 and `disp_valid` is 0. A transfer on the issue port writes the lowest-numbered free slot.
- R2: When every slot is occupied, `iss_ready` is 0 and an issue request is ignored until a slot is released.
- R3: An operand issued with tag 0 is a value that is already present, and it is stored as given.
- R4: If the result bus is valid and carries a nonzero tag equal to an incoming operand's tag in the issue cycle, the bus value is stored and that operand counts as present.
- R5: A waiting entry whose operand tag matches a valid result-bus tag stores the bus value and keeps it after the bus goes idle.
- R6: An entry is offered for dispatch only while both of its operands are present and it has not already been dispatched.
- R7: An entry whose last missing operand is on the result bus in cycle t is offered in cycle t, with the bus value on the matching operand output.
- R8: When several entries are ready, the one that was issued earliest is offered. Age is set by issue order, not by slot number.
- R9: A dispatch transfer happens only on an edge where `disp_valid` and `disp_ready` are both high. A dispatched entry is never offered again.
- R10: An occupied entry is released on the edge where the result bus is valid with that entry's own tag. The slot is free in the next cycle.
- R11: While `flush` is high, `iss_ready` and `disp_valid` are 0. On the following cycle every slot is free.
- R12: Slot i carries the tag TAG_BASE+i, which is never zero. This tag appears on `iss_tag` for the slot the next issue will use, and on `disp_tag` for the offered entry.
- R13: The opcode and address fields leave on the dispatch port unchanged from issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous clear of all slots |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free slot exists and no flush is in progress |
| iss_tag | output | TAG_W | Tag of the slot the next issue will take |
| iss_op | input | OP_W | Operation code |
| iss_addr | input | ADDR_W | Address field for memory operations |
| iss_vj | input | DATA_W | First operand value |
| iss_qj | input | TAG_W | First operand producer tag, 0 when the value is present |
| iss_vk | input | DATA_W | Second operand value |
| iss_qk | input | TAG_W | Second operand producer tag, 0 when the value is present |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_data | input | DATA_W | Broadcast value |
| disp_valid | output | 1 | An entry is offered to the unit |
| disp_ready | input | 1 | Functional unit is free |
| disp_tag | output | TAG_W | Tag of the offered entry |
| disp_op | output | OP_W | Opcode of the offered entry |
| disp_addr | output | ADDR_W | Address field of the offered entry |
| disp_vj | output | DATA_W | First operand, forwarded from the bus when it arrives now |
| disp_vk | output | DATA_W | Second operand, forwarded from the bus when it arrives now |

## Verification
The bench targets the result bus matching at issue time. A design that looked only at stored tags would strand that operand and wait forever for a tag that has already gone by. It also targets same-cycle wakeup: without forwarding, the entry would be offered one cycle late or with a stale operand. Slot reuse is covered by freeing a low slot and refilling it, so that a younger entry sits at a lower index than an older one. An arbiter that picks by index would then dispatch the wrong entry. Full-pool stall, flush during traffic, and repeat offers of a dispatched entry are also exercised, because each would corrupt or duplicate work.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SENT  = 2'd2
  } slot_state_t;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_vj,
  input  logic [TAG_W-1:0]  wr_qj,
  input  logic [DATA_W-1:0] wr_vk,
  input  logic [TAG_W-1:0]  wr_qk,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              launch,
  output logic              busy,
  output logic              rdy,
  output logic [OP_W-1:0]   ent_op,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [DATA_W-1:0] fwd_vj,
  output logic [DATA_W-1:0] fwd_vk
);
  slot_state_t       st;
  logic [DATA_W-1:0] vj, vk;
  logic [TAG_W-1:0]  qj, qk;
  logic              hit_j, hit_k, in_hit_j, in_hit_k, own_hit;

  assign hit_j    = bus_valid && (qj != '0) && (bus_tag == qj);
  assign hit_k    = bus_valid && (qk != '0) && (bus_tag == qk);
  assign in_hit_j = bus_valid && (wr_qj != '0) && (bus_tag == wr_qj);
  assign in_hit_k = bus_valid && (wr_qk != '0) && (bus_tag == wr_qk);
  assign own_hit  = bus_valid && (bus_tag == MY_TAG);

  assign busy     = (st != ST_FREE);
  assign rdy      = (st == ST_WAIT) && ((qj == '0) || hit_j) && ((qk == '0) || hit_k);
  assign fwd_vj   = (qj == '0) ? vj : bus_data;
  assign fwd_vk   = (qk == '0) ? vk : bus_data;
  assign ent_op   = wr_en ? wr_op : op_q;
  assign ent_addr = addr_q;

  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                st <= ST_FREE;
    else if (flush)            st <= ST_FREE;
    else if (wr_en)            st <= ST_WAIT;
    else if (busy && own_hit)  st <= ST_FREE;
    else if (launch)           st <= ST_SENT;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      op_q   <= wr_op;
      addr_q <= wr_addr;
      qj     <= in_hit_j ? '0 : wr_qj;
      vj     <= in_hit_j ? bus_data : wr_vj;
      qk     <= in_hit_k ? '0 : wr_qk;
      vk     <= in_hit_k ? bus_data : wr_vk;
    end else if (st == ST_WAIT) begin
      if (hit_j) begin
        qj <= '0;
        vj <= bus_data;
      end
      if (hit_k) begin
        qk <= '0;
        vk <= bus_data;
      end
    end
  end

  AST_LAUNCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> rdy) else $error("launch without ready operands"); // R6

  AST_WRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy) else $error("write into occupied slot"); // R1

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && hit_j && !flush && !wr_en) |=> (qj == '0)) else $error("wakeup lost"); // R5
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int NUM_ENT = 4
) (
  input  logic [NUM_ENT-1:0] busy,
  output logic [NUM_ENT-1:0] free_sel,
  output logic               any_free
);
  always_comb begin
    free_sel = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_sel    = '0;
        free_sel[i] = 1'b1;
      end
    end
  end
  assign any_free = ~&busy;
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int NUM_ENT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] alloc,
  input  logic [NUM_ENT-1:0] busy,
  input  logic [NUM_ENT-1:0] req,
  output logic [NUM_ENT-1:0] grant
);
  // older_m[i][j]: slot i was allocated before slot j
  logic [NUM_ENT-1:0] older_m [NUM_ENT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = 0; j < NUM_ENT; j++) begin
        if (!rst_n)        older_m[i][j] <= 1'b0;
        else if (alloc[i]) older_m[i][j] <= 1'b0;
        else if (alloc[j]) older_m[i][j] <= busy[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      grant[i] = req[i];
      for (int j = 0; j < NUM_ENT; j++) begin
        if (j != i && req[j] && older_m[j][i]) grant[i] = 1'b0;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("multiple grants"); // R8

  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|grant)) else $error("ready entries but no grant"); // R8
endmodule

// File: rtl/rs_station_array.sv
module rs_station_array #(
  parameter int NUM_ENT  = 4,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  parameter int ADDR_W   = 16,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [ADDR_W-1:0] disp_addr,
  output logic [DATA_W-1:0] disp_vj,
  output logic [DATA_W-1:0] disp_vk
);
  logic [NUM_ENT-1:0] busy, rdy, free_sel, alloc, grant, launch;
  logic               any_free;
  logic [OP_W-1:0]    e_op   [NUM_ENT];
  logic [ADDR_W-1:0]  e_addr [NUM_ENT];
  logic [DATA_W-1:0]  e_vj   [NUM_ENT];
  logic [DATA_W-1:0]  e_vk   [NUM_ENT];

  rs_free_pick #(.NUM_ENT(NUM_ENT)) u_free (
    .busy(busy), .free_sel(free_sel), .any_free(any_free)
  );

  assign iss_ready = any_free && !flush;
  assign alloc     = free_sel & {NUM_ENT{iss_valid && iss_ready}};

  rs_age_pick #(.NUM_ENT(NUM_ENT)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .busy(busy), .req(rdy), .grant(grant)
  );

  assign disp_valid = (|grant) && !flush;
  assign launch     = grant & {NUM_ENT{disp_ready && !flush}};

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    rs_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(TAG_BASE + g))
    ) u_ent (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(alloc[g]),
      .wr_op(iss_op), .wr_addr(iss_addr), .wr_vj(iss_vj), .wr_qj(iss_qj),
      .wr_vk(iss_vk), .wr_qk(iss_qk), .bus_valid(bus_valid), .bus_tag(bus_tag),
      .bus_data(bus_data), .launch(launch[g]), .busy(busy[g]), .rdy(rdy[g]),
      .ent_op(e_op[g]), .ent_addr(e_addr[g]), .fwd_vj(e_vj[g]), .fwd_vk(e_vk[g])
    );
  end

  always_comb begin
    iss_tag = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (free_sel[i]) iss_tag = TAG_W'(TAG_BASE + i);
  end

  always_comb begin
    disp_tag  = '0;
    disp_op   = '0;
    disp_addr = '0;
    disp_vj   = '0;
    disp_vk   = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (grant[i]) begin
        disp_tag  = TAG_W'(TAG_BASE + i);
        disp_op   = e_op[i];
        disp_addr = e_addr[i];
        disp_vj   = e_vj[i];
        disp_vk   = e_vk[i];
      end
    end
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !iss_ready) else $error("issue accepted while full"); // R2

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy == '0)) else $error("slot survived flush"); // R11

  AST_DISP_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_tag != '0)) else $error("zero tag offered"); // R12

  AST_SENT_NOT_REOFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !(disp_valid && disp_tag == $past(disp_tag) && !$past(flush)
      && !$past(bus_valid))) else $error("entry offered twice"); // R9
endmodule

// File: tb/rs_station_array_test.sv
`timescale 1ns/1ps
module rs_station_array_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, iss_valid, bus_valid, disp_ready;
  logic        iss_ready, disp_valid;
  logic [3:0]  iss_tag, iss_op, iss_qj, iss_qk, bus_tag, disp_tag, disp_op;
  logic [15:0] iss_addr, disp_addr;
  logic [31:0] iss_vj, iss_vk, bus_data, disp_vj, disp_vk;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rs_station_array uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .iss_op(iss_op), .iss_addr(iss_addr),
    .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_addr(disp_addr), .disp_vj(disp_vj), .disp_vk(disp_vk)
  );

  // reference model
  bit          m_busy [N];
  bit          m_sent [N];
  logic [3:0]  m_op [N], m_qj [N], m_qk [N];
  logic [15:0] m_addr [N];
  logic [31:0] m_vj [N], m_vk [N];
  int          m_seq [N];
  int          seq_ctr = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit opnd_ok(logic [3:0] q);
    return (q == 4'd0) || (bus_valid && bus_tag == q);
  endfunction

  function automatic logic [31:0] opnd_val(logic [3:0] q, logic [31:0] v);
    return (q == 4'd0) ? v : bus_data;
  endfunction

  task automatic idle();
    flush = 0; iss_valid = 0; bus_valid = 0; disp_ready = 0;
    iss_op = 0; iss_addr = 0; iss_vj = 0; iss_vk = 0; iss_qj = 0; iss_qk = 0;
    bus_tag = 0; bus_data = 0;
  endtask

  task automatic issue(logic [3:0] op, logic [15:0] ad, logic [31:0] vj, logic [3:0] qj,
                       logic [31:0] vk, logic [3:0] qk);
    iss_valid = 1; iss_op = op; iss_addr = ad;
    iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
  endtask

  // compare outputs with the model, then advance one clock
  task automatic tick();
    int fr = -1;
    int pk = -1;
    bit e_rdy, e_dv, acc, lau;
    #1;
    for (int i = 0; i < N; i++) if (!m_busy[i] && fr < 0) fr = i;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_sent[i] && opnd_ok(m_qj[i]) && opnd_ok(m_qk[i]))
        if (pk < 0 || m_seq[i] < m_seq[pk]) pk = i;
    e_rdy = !flush && (fr >= 0);
    e_dv  = !flush && (pk >= 0);
    chk("R2", "iss_ready", 64'(iss_ready), 64'(e_rdy));
    if (e_rdy) chk("R12", "iss_tag", 64'(iss_tag), 64'(fr + 1));
    chk("R6", "disp_valid", 64'(disp_valid), 64'(e_dv));
    if (e_dv) begin
      chk("R8", "disp_tag", 64'(disp_tag), 64'(pk + 1));
      chk("R13", "disp_op", 64'(disp_op), 64'(m_op[pk]));
      chk("R13", "disp_addr", 64'(disp_addr), 64'(m_addr[pk]));
      chk("R7", "disp_vj", 64'(disp_vj), 64'(opnd_val(m_qj[pk], m_vj[pk])));
      chk("R7", "disp_vk", 64'(disp_vk), 64'(opnd_val(m_qk[pk], m_vk[pk])));
    end
    acc = iss_valid && e_rdy;
    lau = e_dv && disp_ready;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (flush) begin
        m_busy[i] = 0;
      end else if (acc && i == fr) begin
        m_busy[i] = 1; m_sent[i] = 0; m_op[i] = iss_op; m_addr[i] = iss_addr;
        m_seq[i] = seq_ctr; seq_ctr++;
        if (iss_qj != 0 && bus_valid && bus_tag == iss_qj) begin m_qj[i] = 0; m_vj[i] = bus_data; end
        else begin m_qj[i] = iss_qj; m_vj[i] = iss_vj; end
        if (iss_qk != 0 && bus_valid && bus_tag == iss_qk) begin m_qk[i] = 0; m_vk[i] = bus_data; end
        else begin m_qk[i] = iss_qk; m_vk[i] = iss_vk; end
      end else if (m_busy[i]) begin
        if (!m_sent[i]) begin
          if (m_qj[i] != 0 && bus_valid && bus_tag == m_qj[i]) begin m_qj[i] = 0; m_vj[i] = bus_data; end
          if (m_qk[i] != 0 && bus_valid && bus_tag == m_qk[i]) begin m_qk[i] = 0; m_vk[i] = bus_data; end
        end
        if (bus_valid && bus_tag == 4'(i + 1)) m_busy[i] = 0;
        else if (lau && i == pk) m_sent[i] = 1;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [3:0] rnd_src_tag();
    int r = $urandom % 4;
    int i = $urandom % N;
    if (r < 2) return 4'd0;
    if (r == 2) return 4'(5 + $urandom % 11);
    return m_busy[i] ? 4'(i + 1) : 4'd0;
  endfunction

  task automatic rnd_inputs();
    int r;
    int i;
    flush      = ($urandom % 64) == 0;
    iss_valid  = $urandom % 2;
    iss_op     = 4'($urandom);
    iss_addr   = 16'($urandom);
    iss_vj     = $urandom;
    iss_vk     = $urandom;
    iss_qj     = rnd_src_tag();
    iss_qk     = rnd_src_tag();
    disp_ready = ($urandom % 4) != 0;
    bus_data   = $urandom;
    r = $urandom % 4;
    i = $urandom % N;
    bus_valid = 0; bus_tag = 0;
    if (r == 1) begin bus_valid = 1; bus_tag = 4'(5 + $urandom % 11); end
    else if (r >= 2 && m_busy[i] && m_sent[i]) begin bus_valid = 1; bus_tag = 4'(i + 1); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_ignore;
    seed_ignore = $urandom(32'd4242);
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_sent[i] = 0; end
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    #1;
    chk("R1", "iss_ready after reset", 64'(iss_ready), 64'd1);
    chk("R1", "disp_valid after reset", 64'(disp_valid), 64'd0);
    chk("R12", "first tag", 64'(iss_tag), 64'd1);
    tick();

    // ready operands at issue
    issue(4'd3, 16'h0040, 32'hA0A0_0001, 4'd0, 32'hB0B0_0002, 4'd0);
    tick();
    idle(); #1;
    chk("R3", "disp_valid", 64'(disp_valid), 64'd1);
    chk("R3", "disp_vj", 64'(disp_vj), 64'hA0A0_0001);
    chk("R3", "disp_vk", 64'(disp_vk), 64'hB0B0_0002);
    disp_ready = 1;
    tick();

    // operand caught from the bus during issue
    idle();
    issue(4'd5, 16'h0123, 32'hDEAD_DEAD, 4'd7, 32'h0000_0D0D, 4'd0);
    bus_valid = 1; bus_tag = 4'd7; bus_data = 32'hC0C0_0003;
    tick();
    idle(); #1;
    chk("R4", "disp_tag", 64'(disp_tag), 64'd2);
    chk("R4", "disp_vj from bus", 64'(disp_vj), 64'hC0C0_0003);
    tick();
    disp_ready = 1;
    tick();
    idle(); #1;
    chk("R9", "sent entry not offered", 64'(disp_valid), 64'd0);
    tick();

    // release by own tag
    bus_valid = 1; bus_tag = 4'd1;
    tick();
    idle(); #1;
    chk("R10", "slot0 reusable", 64'(iss_tag), 64'd1);
    bus_valid = 1; bus_tag = 4'd2;
    tick();
    idle();

    // wakeup and same-cycle dispatch
    issue(4'd6, 16'h0200, 32'h1111_1111, 4'd0, 32'h0, 4'd9);
    tick();
    idle(); #1;
    chk("R6", "waiting not offered", 64'(disp_valid), 64'd0);
    tick();
    bus_valid = 1; bus_tag = 4'd9; bus_data = 32'hF00D_0009; #1;
    chk("R7", "same-cycle offer", 64'(disp_valid), 64'd1);
    chk("R7", "forwarded vk", 64'(disp_vk), 64'hF00D_0009);
    tick();
    idle(); #1;
    chk("R5", "captured vk", 64'(disp_vk), 64'hF00D_0009);
    tick();

    // age order survives slot reuse
    issue(4'd1, 16'h0001, 32'h1, 4'd0, 32'h2, 4'd0);
    tick();
    issue(4'd2, 16'h0002, 32'h3, 4'd0, 32'h4, 4'd0);
    tick();
    idle(); #1;
    chk("R8", "oldest first", 64'(disp_tag), 64'd1);
    disp_ready = 1;
    tick();
    disp_ready = 1;
    tick();
    idle();
    bus_valid = 1; bus_tag = 4'd1;
    tick();
    idle();
    issue(4'd4, 16'h0004, 32'h5, 4'd0, 32'h6, 4'd0);
    tick();
    idle(); #1;
    chk("R8", "older slot2 before younger slot0", 64'(disp_tag), 64'd3);
    disp_ready = 1;
    tick();
    idle(); #1;
    chk("R8", "younger slot0 next", 64'(disp_tag), 64'd1);
    tick();

    // full pool stalls
    issue(4'd7, 16'h0007, 32'h7, 4'd12, 32'h8, 4'd0);
    tick();
    idle(); #1;
    chk("R2", "full stall", 64'(iss_ready), 64'd0);
    issue(4'd8, 16'h0008, 32'h9, 4'd0, 32'hA, 4'd0);
    tick();
    idle();

    // flush
    flush = 1; #1;
    chk("R11", "iss_ready during flush", 64'(iss_ready), 64'd0);
    chk("R11", "disp_valid during flush", 64'(disp_valid), 64'd0);
    tick();
    idle(); #1;
    chk("R11", "empty after flush", 64'(iss_ready), 64'd1);
    chk("R11", "lowest tag after flush", 64'(iss_tag), 64'd1);
    chk("R11", "nothing offered after flush", 64'(disp_valid), 64'd0);
    tick();

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      rnd_inputs();
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule